// File: doc/BRIEF.md
# Register Access Width Adapter

This block sits between a bus master that issues byte, halfword and word accesses and a register file whose registers each have one fixed native width. A fixed map of 4-byte address groups gives the native width of every group. Any bus access whose size differs from that width is turned into a short series of native-width backend accesses. All byte ordering is big-endian: the lowest address holds the most significant byte.

A bus access wider than the register is split into several native accesses at rising addresses. The first of these carries the most significant part of the data. A bus access narrower than the register reads the whole native register. For a read, the block returns the addressed lane. For a write, it merges the new bytes into the value it read and writes the register back. Addresses outside the 512-byte window, unmapped groups, misaligned addresses and the reserved size code are flagged as errors and reach no register.

The bus side uses a valid/ready handshake. The master holds its request stable until ready is high. The backend takes one access per cycle and returns read data in the same cycle as the access.

Top module: `regw_adapter`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready`, `rsp_err` and `be_valid` are low.
- R2: A request whose 10-bit address is 0x200 or higher completes with `rsp_err` high and issues no backend access.
- R3: Size code 3, a halfword at an odd address, a word at an address not divisible by 4, and any address in an unmapped group also complete with `rsp_err` high and issue no backend access.
- R4: The native width of each group, indexed by address[8:2], is as follows. Groups 0-15 are byte. Groups 16-27 are halfword. Groups 28-39 are word. Groups 40-47 are unmapped. In groups 48-63, odd groups are halfword and even groups are word. Groups 64-127 are byte. Every backend access uses the native size of the group it addresses.
- R5: When the request size equals the native width, exactly one backend access is made, at the request address, with the request data.
- R6: A read narrower than the register makes one native read at the address aligned down to the native width. It returns that register's big-endian lane: for a byte from a halfword, an even address gives bits 15:8 and an odd address gives bits 7:0; for a halfword from a word, offset 0 gives bits 31:16 and offset 2 gives bits 15:0.
- R7: An access wider than the register makes size/native accesses at address, address+native and so on. The first carries the most significant bits of the bus data.
- R8: A write narrower than the register makes a native read, then in the next cycle a native write at the same aligned address. Bytes not addressed keep their values.
- R9: `req_ready` is high for exactly one cycle per request. That cycle comes n+1 cycles after the request is taken, where n is the number of backend accesses.
- R10: Size codes are 0 for byte, 1 for halfword and 2 for word, and data is right-justified on both ports. `rsp_rdata` is zero for writes and for errors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Bus request present, held until ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data, right-justified |
| req_ready | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | 32 | Read data, valid with req_ready |
| rsp_err | output | 1 | Error, valid with req_ready |
| be_valid | output | 1 | Backend access this cycle |
| be_write | output | 1 | Backend access is a write |
| be_size | output | 2 | Backend access size code |
| be_addr | output | ADDR_W | Backend byte address |
| be_wdata | output | 32 | Backend write data, right-justified |
| be_rdata | input | 32 | Backend read data, same cycle |

## Verification
The test mixes directed cases with random traffic, and every pairing of request size and native width is tried. Equal sizes tell a pass-through apart from a split. Wide requests to byte and halfword groups show whether the order of the pieces and their data slices are big-endian. Narrow reads at each offset show whether the right lane is picked. Narrow writes followed by full-width read-back show whether the read-modify-write keeps the neighbouring bytes. Addresses at the window edge, in the unmapped groups and misaligned ones show whether errors are flagged without touching the register file.

// File: rtl/regw_pkg.sv
// Shared types and the group width map for the register access width adapter.
// Assumes a 512-byte window split into 128 groups of 4 bytes.
package regw_pkg;

    localparam int GRP_W    = 7;
    localparam int WIN_BYTE = 4 << GRP_W;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_DONE = 2'd2
    } seq_st_t;

    // Width code of a group: 0 unmapped, 1 byte, 2 halfword, 3 word.
    function automatic logic [1:0] grp_code(input logic [GRP_W-1:0] g);
        logic [1:0] c;
        if (g < 7'd16)       c = 2'd1;
        else if (g < 7'd28)  c = 2'd2;
        else if (g < 7'd40)  c = 2'd3;
        else if (g < 7'd48)  c = 2'd0;
        else if (g < 7'd64)  c = g[0] ? 2'd2 : 2'd3;
        else                 c = 2'd1;
        return c;
    endfunction

    // Mask of the low bytes covered by a size code.
    function automatic logic [31:0] size_mask(input logic [1:0] s);
        logic [31:0] m;
        case (s)
            2'd0:    m = 32'h0000_00ff;
            2'd1:    m = 32'h0000_ffff;
            default: m = 32'hffff_ffff;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/regw_decode.sv
// Request decoder: looks up the native width of the addressed group and plans
// the backend sequence. Purely combinational; assumes a byte address.
module regw_decode
    import regw_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output logic              err,
    output logic [1:0]        nat_log,
    output logic              narrow,
    output logic [ADDR_W-1:0] base,
    output logic [1:0]        last
);
    localparam logic [ADDR_W-1:0] WIN_LIM = ADDR_W'(WIN_BYTE);

    logic [1:0] code;
    logic       misal;

    // Look up the group width and classify the request.
    always_comb begin
        code    = grp_code(addr[GRP_W+1:2]);
        nat_log = (code == 2'd0) ? 2'd0 : code - 2'd1;
        misal   = ((size == 2'd1) && addr[0]) ||
                  ((size == 2'd2) && (addr[1:0] != 2'd0));
        err     = (addr >= WIN_LIM) || (size == 2'd3) || (code == 2'd0) || misal;
        narrow  = (size < nat_log);
        base    = narrow ? (addr & ~((ADDR_W'(1) << nat_log) - ADDR_W'(1))) : addr;
        last    = narrow ? 2'd0 : 2'((3'd1 << (size - nat_log)) - 3'd1);
    end

endmodule

// File: rtl/regw_lane.sv
// Big-endian lane logic: extracts a narrow field from a native register value
// and merges narrow write data into it. Assumes the narrow access is aligned.
module regw_lane
    import regw_pkg::*;
(
    input  logic [31:0] nat_val,
    input  logic [1:0]  nat_log,
    input  logic [1:0]  sub_log,
    input  logic [1:0]  addr_lo,
    input  logic [31:0] sub_wdata,
    output logic [31:0] sub_rdata,
    output logic [31:0] merged
);
    logic [2:0]  off;
    logic [2:0]  gap;
    logic [4:0]  sh;
    logic [31:0] smask;

    // Bit distance of the addressed lane from bit 0 of the native value.
    always_comb begin
        off       = {1'b0, addr_lo & 2'((3'd1 << nat_log) - 3'd1)};
        gap       = (3'd1 << nat_log) - (3'd1 << sub_log) - off;
        sh        = {gap[1:0], 3'b000};
        smask     = size_mask(sub_log);
        sub_rdata = (nat_val >> sh) & smask;
        merged    = (nat_val & ~(smask << sh)) | ((sub_wdata & smask) << sh);
    end

endmodule

// File: rtl/regw_adapter.sv
// Register access width adapter top. Takes one bus request at a time, issues
// one native-width backend access per cycle, and pulses req_ready once the last
// access is done. Assumes the master holds the request stable until req_ready
// and that the backend returns read data in the cycle of the access.
module regw_adapter
    import regw_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              req_ready,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_err,
    output logic              be_valid,
    output logic              be_write,
    output logic [1:0]        be_size,
    output logic [ADDR_W-1:0] be_addr,
    output logic [31:0]       be_wdata,
    input  logic [31:0]       be_rdata
);
    seq_st_t           st;
    logic              r_wr, r_err, r_narrow, ph;
    logic [1:0]        r_sz, r_nl, r_last, k;
    logic [ADDR_W-1:0] r_addr, r_base;
    logic [31:0]       r_wd, acc;

    logic              d_err, d_narrow;
    logic [1:0]        d_nl, d_last;
    logic [ADDR_W-1:0] d_base;
    logic [31:0]       lane_rd, lane_merged, nmask, slice;
    logic [1:0]        idx;

    regw_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr    (req_addr),
        .size    (req_size),
        .err     (d_err),
        .nat_log (d_nl),
        .narrow  (d_narrow),
        .base    (d_base),
        .last    (d_last)
    );

    regw_lane u_lane (
        .nat_val   (acc),
        .nat_log   (r_nl),
        .sub_log   (r_sz),
        .addr_lo   (r_addr[1:0]),
        .sub_wdata (r_wd),
        .sub_rdata (lane_rd),
        .merged    (lane_merged)
    );

    // Backend access for the current step of the sequence.
    always_comb begin
        nmask    = size_mask(r_nl);
        idx      = r_last - k;
        slice    = (r_wd >> (32'(idx) * (32'd8 << r_nl))) & nmask;
        be_valid = (st == ST_BUSY);
        be_write = r_wr && (!r_narrow || ph);
        be_size  = r_nl;
        be_addr  = r_base + (ADDR_W'(k) << r_nl);
        be_wdata = r_narrow ? lane_merged : slice;
    end

    // Completion outputs, present only in the done cycle.
    always_comb begin
        req_ready = (st == ST_DONE);
        rsp_err   = (st == ST_DONE) && r_err;
        rsp_rdata = ((st == ST_DONE) && !r_wr && !r_err) ? (r_narrow ? lane_rd : acc) : 32'd0;
    end

    // Sequencer: accept, step through backend accesses, complete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            r_wr     <= 1'b0;
            r_err    <= 1'b0;
            r_narrow <= 1'b0;
            ph       <= 1'b0;
            r_sz     <= 2'd0;
            r_nl     <= 2'd0;
            r_last   <= 2'd0;
            k        <= 2'd0;
            r_addr   <= '0;
            r_base   <= '0;
            r_wd     <= 32'd0;
            acc      <= 32'd0;
        end else begin
            case (st)
                ST_IDLE: if (req_valid) begin
                    r_wr     <= req_write;
                    r_sz     <= req_size;
                    r_addr   <= req_addr;
                    r_wd     <= req_wdata;
                    r_err    <= d_err;
                    r_nl     <= d_nl;
                    r_narrow <= d_narrow;
                    r_base   <= d_base;
                    r_last   <= d_last;
                    k        <= 2'd0;
                    ph       <= 1'b0;
                    acc      <= 32'd0;
                    st       <= d_err ? ST_DONE : ST_BUSY;
                end
                ST_BUSY: begin
                    if (!be_write)
                        acc <= r_narrow ? (be_rdata & nmask)
                                        : ((acc << (32'd8 << r_nl)) | (be_rdata & nmask));
                    if (r_narrow && r_wr && !ph)
                        ph <= 1'b1;
                    else if (k == r_last)
                        st <= ST_DONE;
                    else
                        k <= k + 2'd1;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/regw_adapter_chk.sv
// Protocol checker for the width adapter; attached by bind below.
module regw_adapter_chk
    import regw_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        req_size,
    input logic              req_ready,
    input logic              rsp_err,
    input logic              be_valid,
    input logic              be_write,
    input logic [1:0]        be_size,
    input logic [ADDR_W-1:0] be_addr
);
    localparam logic [ADDR_W-1:0] WIN_LIM = ADDR_W'(WIN_BYTE);

    p_in_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        be_valid |-> (be_addr < WIN_LIM));

    p_err_no_access_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && rsp_err) |-> !$past(be_valid));

    p_native_size_r4: assert property (@(posedge clk) disable iff (!rst_n)
        be_valid |-> (grp_code(be_addr[GRP_W+1:2]) == be_size + 2'd1));

    p_read_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (be_valid && be_write && (req_size < be_size)) |->
            ($past(be_valid && !be_write) && (be_addr == $past(be_addr))));

    p_ready_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready);

    p_no_overlap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        be_valid |-> !req_ready);

endmodule

bind regw_adapter regw_adapter_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_size  (req_size),
    .req_ready (req_ready),
    .rsp_err   (rsp_err),
    .be_valid  (be_valid),
    .be_write  (be_write),
    .be_size   (be_size),
    .be_addr   (be_addr)
);

// File: tb/sim_regw_adapter.sv
`timescale 1ns/100ps
// Bench for the width adapter: byte-array backend, shadow model, mixed
// directed and seeded random requests.
module sim_regw_adapter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [9:0]  req_addr = 10'd0;
    logic [31:0] req_wdata = 32'd0;
    logic        req_ready, rsp_err, be_valid, be_write;
    logic [31:0] rsp_rdata, be_wdata, be_rdata;
    logic [1:0]  be_size;
    logic [9:0]  be_addr;

    logic [7:0] mem [512];
    logic [7:0] shadow [512];
    int n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    regw_adapter u0 (.*);

    // Backend: big-endian byte array, same-cycle read data.
    always_comb begin
        be_rdata = 32'd0;
        for (int j = 0; j < 4; j++)
            if (j < (1 << be_size))
                be_rdata = (be_rdata << 8) | 32'(mem[(int'(be_addr) + j) % 512]);
    end

    always @(posedge clk)
        if (be_valid && be_write)
            for (int j = 0; j < 4; j++)
                if (j < (1 << be_size))
                    mem[(int'(be_addr) + j) % 512] <= 8'(be_wdata >> (8 * ((1 << be_size) - 1 - j)));

    // Native width log2 of an address, -1 when unmapped (map of R4).
    function automatic int tb_wlog(input int a);
        int g = (a % 512) / 4;
        if (g < 16) return 0;
        if (g < 28) return 1;
        if (g < 40) return 2;
        if (g < 48) return -1;
        if (g < 64) return (g % 2 == 1) ? 1 : 2;
        return 0;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic xfer(input bit wr, input int sz, input int addr,
                        input logic [31:0] wd, input string req);
        int nl = tb_wlog(addr);
        bit exp_err = (addr >= 512) || (sz == 3) || (nl < 0) ||
                      (sz == 1 && addr % 2 != 0) || (sz == 2 && addr % 4 != 0);
        int exp_ops = exp_err ? 0 : (sz >= nl) ? (1 << (sz - nl)) : (wr ? 2 : 1);
        logic [31:0] exp_rd = 32'd0;
        int cyc = 0, ops = 0, badsz = 0;
        logic [31:0] got_rd;
        logic got_err;
        if (!exp_err && !wr)
            for (int i = 0; i < (1 << sz); i++)
                exp_rd = (exp_rd << 8) | 32'(shadow[addr + i]);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = 2'(sz);
        req_addr = 10'(addr); req_wdata = wd;
        do begin
            @(negedge clk);
            cyc++;
            if (be_valid) begin
                ops++;
                if (tb_wlog(int'(be_addr)) != int'(be_size)) badsz++;
            end
        end while (!req_ready && cyc < 40);
        got_rd = rsp_rdata; got_err = rsp_err;
        req_valid = 1'b0;
        if (!exp_err && wr)
            for (int i = 0; i < (1 << sz); i++)
                shadow[addr + i] = 8'(wd >> (8 * ((1 << sz) - 1 - i)));
        check(got_err == exp_err, exp_err ? "R2/R3" : req, "error flag", 32'(got_err), 32'(exp_err));
        check(ops == exp_ops, req, "backend access count", ops, exp_ops);
        check(cyc == exp_ops + 1, "R9", "ready latency", cyc, exp_ops + 1);
        check(got_rd == exp_rd, wr ? "R10" : req, "read data", got_rd, exp_rd);
        check(badsz == 0, "R4", "non-native backend size", badsz, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 512; i++) begin
            mem[i] = 8'(i * 7 + 3);
            shadow[i] = 8'(i * 7 + 3);
        end
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check(!req_ready && !rsp_err && !be_valid, "R1", "outputs in reset",
              {29'd0, req_ready, rsp_err, be_valid}, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check(!req_ready && !rsp_err && !be_valid, "R1", "outputs after reset",
              {29'd0, req_ready, rsp_err, be_valid}, 32'd0);

        xfer(0, 0, 'h005, 0, "R5");              // byte from byte group
        xfer(0, 2, 'h074, 0, "R5");              // word from word group
        xfer(0, 0, 'h042, 0, "R6");              // byte of halfword, even -> 15:8
        xfer(0, 0, 'h043, 0, "R6");              // byte of halfword, odd -> 7:0
        xfer(0, 1, 'h078, 0, "R6");              // halfword of word, offset 0
        xfer(0, 1, 'h07a, 0, "R6");              // halfword of word, offset 2
        xfer(0, 0, 'h0c1, 0, "R6");              // byte of word, offset 1
        xfer(0, 2, 'h010, 0, "R7");              // word split into four bytes
        xfer(1, 2, 'h044, 32'hA1B2C3D4, "R7");   // word split into two halfwords
        xfer(1, 1, 'h120, 32'h0000BEEF, "R7");   // halfword split into two bytes
        xfer(0, 2, 'h044, 0, "R7");
        xfer(1, 0, 'h082, 32'h0000005A, "R8");   // byte into word register
        xfer(0, 2, 'h080, 0, "R8");
        xfer(1, 1, 'h0c4 + 'h4, 32'h00001234, "R8"); // halfword into word group 50
        xfer(0, 2, 'h0c8, 0, "R8");
        xfer(1, 0, 'h0d5, 32'h00000077, "R8");   // byte into halfword group 53
        xfer(0, 1, 'h0d4, 0, "R8");
        xfer(0, 0, 'h200, 0, "R2");              // first address past the window
        xfer(1, 2, 'h3fc, 32'hFFFFFFFF, "R2");
        xfer(0, 0, 'h1ff, 0, "R5");              // last byte inside the window
        xfer(0, 1, 'h0a0, 0, "R3");              // unmapped group
        xfer(0, 1, 'h043, 0, "R3");              // misaligned halfword
        xfer(0, 2, 'h072, 0, "R3");              // misaligned word
        xfer(0, 3, 'h070, 0, "R3");              // reserved size code

        for (int n = 0; n < 400; n++) begin
            int sz = $urandom % 8;
            int a  = $urandom % 1024;
            sz = (sz == 7) ? 3 : sz % 3;
            if ($urandom % 10 < 8 && sz < 3)
                a = a & ~((1 << sz) - 1);
            if ($urandom % 10 < 8)
                a = a % 512;
            xfer($urandom % 2, sz, a, $urandom, "R5/R6/R7/R8");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule